// File: doc/BRIEF.md
# Programmable PIO Strobe Timing Generator

This block times programmed-I/O transfers on a parallel disk interface with two channels of two drives each. It splits every transfer into three phases: address setup, strobe active and recovery. It drives a read or a write strobe only during the active phase, and it holds a busy flag for the whole cycle. Each timing set holds a 2-bit setup code and a byte that packs the active and recovery counts. Drives 0 and 1 on the primary channel each have their own set. Drives 2 and 3 on the secondary channel share one set. A separate command-timing byte governs accesses to the drive's command register block, and those accesses always use the longest setup.

Software loads the timing bytes through a simple write port. Each cycle is started by a one-clock request pulse that carries the drive number, a command-block flag and the direction. A request that arrives while a cycle is running is kept in a one-entry holding slot. It starts in the clock right after the current recovery ends, so busy does not drop in between. An input selects the later silicon behaviour, in which recovery is one clock longer than programmed.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, busy and both strobes are low, every drive runs 4 setup, 16 active and 16 recovery clocks, and command-block accesses run 4/16/16.
- R2: A setup write takes the code from data bits 7:6. Code 00 gives 4 setup clocks, 01 gives 2, 10 gives 3 and 11 gives 5.
- R3: A timing byte places the active count in bits 7:4 and the recovery count in bits 3:0. A nibble of 0 means 16 clocks, and any other value N means N clocks.
- R4: An active nibble of 1 gives 2 active clocks, because the strobe is never shorter than 2 clocks.
- R5: When late_rev is high, the recovery phase lasts one clock longer than its nibble gives, so a nibble of 0 gives 17 clocks.
- R6: Configuration addresses are: 1 and 2 for drive 0 (setup, timing byte), 3 and 4 for drive 1, and 5 and 6 for the set shared by drives 2 and 3. Drives 2 and 3 always run the same timing, and a write to one set leaves the other drives unchanged.
- R7: A request with req_cmd high uses 4 setup clocks and the timing byte at address 0, whichever drive it names. Writing 0 to address 0 gives 4/16/16.
- R8: rd_strobe (for reads) or wr_strobe (for writes) is high for exactly the active clocks and never together with the other strobe. busy rises in the clock after the request and stays high for setup plus active plus recovery clocks.
- R9: A request pulse that arrives during a busy cycle starts its own cycle directly after the current recovery, with busy held high throughout.
- R10: Timing values are captured when a cycle starts. A configuration write made during a cycle changes only the cycles that start after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration address (0 command byte, 1 to 6 drive sets) |
| cfg_wdata | input | 8 | Configuration write data |
| late_rev | input | 1 | Later silicon: recovery runs one extra clock |
| req | input | 1 | One-clock cycle request pulse |
| req_drive | input | 2 | Drive number 0 to 3 |
| req_cmd | input | 1 | Access targets the command register block |
| req_read | input | 1 | 1 read, 0 write |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| busy | output | 1 | Cycle in progress |

## Verification
Each run measures the setup, active and recovery lengths separately, by counting the clocks before the first strobe, during the strobes and after the last strobe. This shows which field the design actually decoded. Stepping through all four setup codes with a fixed timing byte confirms the nonlinear setup mapping. Nibble values 0, 1 and 15 separate the 16-clock wrap, the 2-clock active floor and plain linear decoding. Two further patterns isolate the start-time capture and the holding slot: a request injected mid-cycle and a configuration write injected mid-cycle. In both, busy must stay continuous and the old timing must be kept.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] recov;
  } timing_t;

  // nonlinear 2-bit setup code to clocks
  function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      2'b00:   r = CNT_W'(4);
      2'b01:   r = CNT_W'(2);
      2'b10:   r = CNT_W'(3);
      default: r = CNT_W'(5);
    endcase
    return r;
  endfunction

  // nibble to clocks: 0 wraps to 16, optional floor of 2
  function automatic logic [CNT_W-1:0] nibble_clocks(input logic [3:0] n,
                                                     input logic floor2);
    logic [CNT_W-1:0] r;
    if (n == 4'd0)
      r = CNT_W'(16);
    else if (floor2 && n == 4'd1)
      r = CNT_W'(2);
    else
      r = CNT_W'(n);
    return r;
  endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
  import pio_timing_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int NUM_SETS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              late_rev,
  input  logic [1:0]        sel_drive,
  input  logic              sel_cmd,
  output timing_t           timing
);

  localparam int SET_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam int CODE_H = DATA_W - 1;
  localparam int CODE_L = DATA_W - 2;

  logic [1:0]        set_code [NUM_SETS];
  logic [DATA_W-1:0] set_rw   [NUM_SETS];
  logic [DATA_W-1:0] cmd_rw;

  // one register pair per timing set
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [1:0]        code_q;
    logic [DATA_W-1:0] rw_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        code_q <= '0;
        rw_q   <= '0;
      end else if (we) begin
        if (addr == ADDR_W'(2*s+1)) code_q <= wdata[CODE_H:CODE_L];
        if (addr == ADDR_W'(2*s+2)) rw_q   <= wdata;
      end
    end
    assign set_code[s] = code_q;
    assign set_rw[s]   = rw_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                            cmd_rw <= '0;
    else if (we && addr == ADDR_W'(0))  cmd_rw <= wdata;
  end

  // both secondary drives map onto the last set
  logic [SET_W-1:0] set_idx;
  assign set_idx = sel_drive[1] ? SET_W'(NUM_SETS-1) : SET_W'(sel_drive[0]);

  logic [1:0]        cur_code;
  logic [DATA_W-1:0] cur_rw;

  always_comb begin
    if (sel_cmd) begin
      cur_code = 2'b00;
      cur_rw   = cmd_rw;
    end else begin
      cur_code = set_code[set_idx];
      cur_rw   = set_rw[set_idx];
    end
    timing.setup  = setup_clocks(cur_code);
    timing.active = nibble_clocks(cur_rw[DATA_W-1:DATA_W-4], 1'b1);
    timing.recov  = nibble_clocks(cur_rw[3:0], 1'b0) + CNT_W'(late_rev);
  end

  p_setup_range_r2: assert property (@(posedge clk) disable iff (rst)
    timing.setup >= CNT_W'(2) && timing.setup <= CNT_W'(5));

  p_active_floor_r4: assert property (@(posedge clk) disable iff (rst)
    timing.active >= CNT_W'(2) && timing.active <= CNT_W'(16));

  p_late_extra_r5: assert property (@(posedge clk) disable iff (rst)
    late_rev |-> timing.recov >= CNT_W'(2));

  p_cmd_slow_setup_r7: assert property (@(posedge clk) disable iff (rst)
    sel_cmd |-> timing.setup == CNT_W'(4));

  p_reset_slowest_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !late_rev) |->
      (timing.setup == CNT_W'(4) && timing.active == CNT_W'(16)
       && timing.recov == CNT_W'(16)));

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
  import pio_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic [1:0] req_drive,
  input  logic       req_cmd,
  input  logic       req_read,
  input  timing_t    timing,
  output logic [1:0] sel_drive,
  output logic       sel_cmd,
  output logic       rd_strobe,
  output logic       wr_strobe,
  output logic       busy
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e           state, nstate;
  logic [CNT_W-1:0] cnt, ncnt;
  logic [CNT_W-1:0] lat_act, lat_rec;
  logic             dir_rd, ndir;

  logic             pend_v, pend_cmd, pend_read;
  logic [1:0]       pend_drive;

  logic can_start, start, sel_read;

  assign can_start = (state == PH_IDLE) || (state == PH_RECOV && cnt == '0);
  assign start     = can_start && (pend_v || req);
  assign sel_drive = pend_v ? pend_drive : req_drive;
  assign sel_cmd   = pend_v ? pend_cmd   : req_cmd;
  assign sel_read  = pend_v ? pend_read  : req_read;

  always_comb begin
    nstate = state;
    ncnt   = cnt;
    ndir   = dir_rd;
    case (state)
      PH_SETUP: begin
        if (cnt == '0) begin
          nstate = PH_ACTIVE;
          ncnt   = lat_act - ONE;
        end else ncnt = cnt - ONE;
      end
      PH_ACTIVE: begin
        if (cnt == '0) begin
          nstate = PH_RECOV;
          ncnt   = lat_rec - ONE;
        end else ncnt = cnt - ONE;
      end
      PH_RECOV: begin
        if (cnt == '0) nstate = PH_IDLE;
        else           ncnt   = cnt - ONE;
      end
      default: ;
    endcase
    if (start) begin
      nstate = PH_SETUP;
      ncnt   = timing.setup - ONE;
      ndir   = sel_read;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PH_IDLE;
      cnt       <= '0;
      lat_act   <= '0;
      lat_rec   <= '0;
      dir_rd    <= 1'b0;
      rd_strobe <= 1'b0;
      wr_strobe <= 1'b0;
      busy      <= 1'b0;
    end else begin
      state     <= nstate;
      cnt       <= ncnt;
      dir_rd    <= ndir;
      rd_strobe <= (nstate == PH_ACTIVE) &&  ndir;
      wr_strobe <= (nstate == PH_ACTIVE) && !ndir;
      busy      <= (nstate != PH_IDLE);
      if (start) begin
        lat_act <= timing.active;
        lat_rec <= timing.recov;
      end
    end
  end

  // one-entry holding slot for requests that arrive mid-cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v     <= 1'b0;
      pend_drive <= '0;
      pend_cmd   <= 1'b0;
      pend_read  <= 1'b0;
    end else if (can_start && pend_v) begin
      pend_v <= req;
      if (req) begin
        pend_drive <= req_drive;
        pend_cmd   <= req_cmd;
        pend_read  <= req_read;
      end
    end else if (!can_start && req && !pend_v) begin
      pend_v     <= 1'b1;
      pend_drive <= req_drive;
      pend_cmd   <= req_cmd;
      pend_read  <= req_read;
    end
  end

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe && wr_strobe));

  p_strobe_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe || wr_strobe) |-> busy);

  p_req_starts_r8: assert property (@(posedge clk) disable iff (rst)
    (state == PH_IDLE && req) |=> busy);

  p_pending_chain_r9: assert property (@(posedge clk) disable iff (rst)
    (state == PH_RECOV && cnt == '0 && pend_v) |=> (busy && state == PH_SETUP));

  p_cnt_limit_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(16));

  p_capture_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (state == PH_SETUP || state == PH_ACTIVE) |=> ($stable(lat_act) && $stable(lat_rec)));

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
  import pio_timing_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int NUM_SETS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              late_rev,
  input  logic              req,
  input  logic [1:0]        req_drive,
  input  logic              req_cmd,
  input  logic              req_read,
  output logic              rd_strobe,
  output logic              wr_strobe,
  output logic              busy
);

  timing_t    timing;
  logic [1:0] sel_drive;
  logic       sel_cmd;

  pio_timing_regs #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NUM_SETS(NUM_SETS)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .late_rev (late_rev),
    .sel_drive(sel_drive),
    .sel_cmd  (sel_cmd),
    .timing   (timing)
  );

  pio_phase_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_drive(req_drive),
    .req_cmd  (req_cmd),
    .req_read (req_read),
    .timing   (timing),
    .sel_drive(sel_drive),
    .sel_cmd  (sel_cmd),
    .rd_strobe(rd_strobe),
    .wr_strobe(wr_strobe),
    .busy     (busy)
  );

endmodule

// File: tb/pio_strobe_timer_test.sv
module pio_strobe_timer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       late_rev = 1'b0;
  logic       req = 1'b0;
  logic [1:0] req_drive = '0;
  logic       req_cmd = 1'b0;
  logic       req_read = 1'b0;
  logic       rd_strobe, wr_strobe, busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int m_busy, m_rd, m_wr, m_both, m_setup, m_rec, m_pulses;

  always #5 clk = ~clk;

  pio_strobe_timer uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .late_rev(late_rev), .req(req),
    .req_drive(req_drive), .req_cmd(req_cmd), .req_read(req_read),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[2:0]; cfg_wdata = d[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // launch a request, then sample each negedge until busy drops
  task automatic measure(input int drv, input int cmd, input int rd,
                         input int inj_req_at, input int inj_drv, input int inj_rd,
                         input int inj_we_at, input int inj_addr, input int inj_data);
    int  idx;
    bit  seen, prev, strb;
    @(negedge clk);
    req = 1'b1; req_drive = drv[1:0]; req_cmd = cmd[0]; req_read = rd[0];
    @(negedge clk);
    req = 1'b0;
    m_busy = 0; m_rd = 0; m_wr = 0; m_both = 0; m_setup = 0; m_rec = 0; m_pulses = 0;
    idx = 0; seen = 0; prev = 0;
    while (busy && idx < 1000) begin
      m_busy++;
      strb = rd_strobe | wr_strobe;
      if (rd_strobe) m_rd++;
      if (wr_strobe) m_wr++;
      if (rd_strobe && wr_strobe) m_both++;
      if (strb && !prev) m_pulses++;
      if (!seen && !strb) m_setup++;
      if (strb) begin seen = 1; m_rec = 0; end
      else if (seen) m_rec++;
      prev = strb;
      req = (idx == inj_req_at);
      if (idx == inj_req_at) begin
        req_drive = inj_drv[1:0]; req_cmd = 1'b0; req_read = inj_rd[0];
      end
      cfg_we = (idx == inj_we_at);
      if (idx == inj_we_at) begin
        cfg_addr = inj_addr[2:0]; cfg_wdata = inj_data[7:0];
      end
      idx++;
      @(negedge clk);
    end
    req = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic run(input int drv, input int cmd, input int rd);
    measure(drv, cmd, rd, -1, 0, 0, -1, 0, 0);
  endtask

  task automatic expect_srt(input string tag, input int s, input int a, input int r);
    check({tag, " setup"}, m_setup, s);
    check({tag, " active"}, m_rd + m_wr, a);
    check({tag, " recovery"}, m_rec, r);
  endtask

  task automatic t_reset;
    check("R1 busy after reset", busy, 0);
    check("R1 rd_strobe after reset", rd_strobe, 0);
    check("R1 wr_strobe after reset", wr_strobe, 0);
    run(0, 0, 1);
    expect_srt("R1 R3 drive0 default", 4, 16, 16);
    run(3, 0, 1);
    expect_srt("R1 drive3 default", 4, 16, 16);
    run(1, 1, 1);
    expect_srt("R1 command default", 4, 16, 16);
  endtask

  task automatic t_setup_codes;
    int exp_s [4] = '{4, 2, 3, 5};
    cfg_write(4, 8'h32);
    for (int c = 0; c < 4; c++) begin
      cfg_write(3, c << 6);
      run(1, 0, 1);
      check($sformatf("R2 setup code %0d", c), m_setup, exp_s[c]);
    end
    check("R3 active nibble 3", m_rd, 3);
    check("R3 recovery nibble 2", m_rec, 2);
  endtask

  task automatic t_nibbles;
    cfg_write(2, 8'h1F);
    run(0, 0, 1);
    check("R4 active nibble 1 floor", m_rd, 2);
    check("R3 recovery nibble 15", m_rec, 15);
    cfg_write(2, 8'h85);
    run(0, 0, 1);
    expect_srt("R3 byte 0x85", 4, 8, 5);
    cfg_write(2, 8'h0A);
    run(0, 0, 1);
    expect_srt("R3 active wrap 16", 4, 16, 10);
  endtask

  task automatic t_late_rev;
    late_rev = 1'b1;
    cfg_write(2, 8'h43);
    run(0, 0, 1);
    expect_srt("R5 late recovery +1", 4, 4, 4);
    cfg_write(2, 8'h00);
    run(0, 0, 1);
    check("R5 late recovery wrap 17", m_rec, 17);
    check("R5 busy total", m_busy, 37);
    late_rev = 1'b0;
  endtask

  task automatic t_secondary;
    cfg_write(5, 8'h40);
    cfg_write(6, 8'h23);
    run(2, 0, 1);
    expect_srt("R6 drive2 shared set", 2, 2, 3);
    run(3, 0, 1);
    expect_srt("R6 drive3 shared set", 2, 2, 3);
    run(0, 0, 1);
    expect_srt("R6 drive0 unaffected", 4, 16, 16);
    run(1, 0, 1);
    expect_srt("R6 drive1 unaffected", 5, 3, 2);
  endtask

  task automatic t_cmd;
    cfg_write(0, 8'h22);
    run(2, 1, 1);
    expect_srt("R7 command byte 0x22", 4, 2, 2);
    cfg_write(0, 8'h00);
    run(2, 1, 1);
    expect_srt("R7 command zero slowest", 4, 16, 16);
  endtask

  task automatic t_direction;
    run(2, 0, 0);
    check("R8 write uses wr_strobe", m_wr, 2);
    check("R8 write no rd_strobe", m_rd, 0);
    check("R8 busy length write", m_busy, 7);
    run(2, 0, 1);
    check("R8 read uses rd_strobe", m_rd, 2);
    check("R8 read no wr_strobe", m_wr, 0);
    check("R8 one strobe pulse", m_pulses, 1);
  endtask

  task automatic t_pending;
    measure(2, 0, 1, 2, 1, 0, -1, 0, 0);
    check("R9 busy continuous total", m_busy, 17);
    check("R9 two strobe pulses", m_pulses, 2);
    check("R9 first read active", m_rd, 2);
    check("R9 held write active", m_wr, 3);
    check("R9 held recovery", m_rec, 2);
    check("R8 never both strobes", m_both, 0);
  endtask

  task automatic t_midwrite;
    cfg_write(2, 8'h44);
    measure(0, 0, 1, -1, 0, 0, 1, 2, 8'h22);
    expect_srt("R10 cycle keeps old timing", 4, 4, 4);
    run(0, 0, 1);
    expect_srt("R10 next cycle new timing", 4, 2, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_setup_codes();
    t_nibbles();
    t_late_rev();
    t_secondary();
    t_cmd();
    t_direction();
    t_pending();
    t_midwrite();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule